// File: doc/BRIEF.md
# UART Autobaud Sync Responder

This block watches a UART receive line while a device waits to be loaded over a serial link. It locks onto the host's bit rate by timing a single sync character, which is backspace (0x08). The character is sent least-significant bit first with one start bit, so its first low stretch is exactly four bit cells long: the start bit followed by data bits 0 to 2. The block divides that low time by four to get a bit divisor in clock cycles. It then samples the rest of the character at its bit centres, and locks only if what it sees matches 0x08 followed by a high stop bit.

When it locks, the block raises a sticky `synced` flag for the packet logic downstream and publishes the divisor. It then transmits a 24-byte identification reply at the host's rate with no delay. The reply is made of 22 configurable bytes, followed by a line feed and a carriage return.

After lock, a receiver running at the same rate delivers each further byte as plain data, including any later backspace. The format is 8 data bits, no parity and one stop bit. Each bit is sampled at the centre of its cell.

Top module: `uart_autobaud_sync`

## Requirements
- R1: After reset `tx_o` is high, `synced_o` is low, `baud_div_o` is 0 and `rx_valid_o` is low; `baud_div_o` remains 0 for as long as `synced_o` is low.
- R2: After reset, line activity is ignored until `rx_i` has been high for 10*DIV_MAX consecutive clock cycles; a sync character that begins earlier produces no lock and no reply.
- R3: Lock requires the character 0x08 (LSB first, one low start bit). The divisor is floor(L/4), where L is the length in clocks of the first low stretch. Bit 3 must be high, bits 4 to 7 low, and the stop bit high, each sampled at its cell centre. Any other character (for example 0x18 or 0x00) gives no lock.
- R4: A lock happens only if floor(L/4) lies in [DIV_MIN, DIV_MAX]. Outside that range there is no lock, and the block goes back to waiting for an idle line.
- R5: On lock `synced_o` goes high and `baud_div_o` shows the divisor; both hold until reset.
- R6: The reply is 24 frames of 8N1 at `baud_div_o` clocks per bit. Frame i, for i from 0 to 21, carries `id_table_i[8*i +: 8]`: entries 0 to 14 are the product code, 15 to 17 the version and 18 to 21 reserved. Frame 22 is 0x0A and frame 23 is 0x0D.
- R7: The reply's first start bit begins no later than two bit times after the sync stop-bit centre. The reply is sent once per reset, and `tx_o` is high whenever it is not sending.
- R8: After lock, every 8N1 byte on `rx_i` appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse. A later 0x08 is delivered as data and changes neither `synced_o` nor `baud_div_o`, and it starts no new reply.
- R9: A received byte whose stop bit samples low is dropped. A new frame starts only on a high-to-low transition, so the next valid byte is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line (idle high) |
| id_table_i | input | 176 | Configurable reply bytes, byte i at bits 8*i+7 to 8*i |
| tx_o | output | 1 | Serial transmit line (idle high) |
| baud_div_o | output | $clog2(DIV_MAX+2) | Locked bit period in clocks, 0 before lock |
| synced_o | output | 1 | Lock reached, sticky until reset |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |

## Verification
The bench probes the bit-time limits one cycle on each side. At 7 and 41 clocks per bit, a design with an off-by-one range test or measurement cutoff would lock. At 8 and 40 clocks per bit, such a design would refuse to lock. A sync character sent too soon after reset catches a missing idle guard, which would make the block lock in the middle of traffic. The characters 0x18 and 0x00 have the right leading low stretch but the wrong tail; a design that measures without checking the tail would lock on them. After lock, a second backspace and a frame with a low stop bit show whether the block re-syncs, sends the reply again or lets a framing error leak out as a bogus byte.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

    localparam logic [7:0] SYNC_CHAR = 8'h08;
    localparam logic [7:0] ID_LF     = 8'h0A;
    localparam logic [7:0] ID_CR     = 8'h0D;
    localparam int         ID_CFG    = 22;
    localparam int         ID_LEN    = ID_CFG + 2;
    localparam int         CHECK_LAST = 5;

    typedef enum logic [2:0] {
        DS_QUIET,
        DS_ARMED,
        DS_MEASURE,
        DS_CHECK,
        DS_LOCKED
    } det_state_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_START,
        RS_DATA,
        RS_STOP
    } rx_state_e;

    // Expected level at check step k after the first rising edge of the
    // sync character: steps 0..4 cover data bits 3..7, step 5 the stop bit.
    function automatic logic check_bit(input logic [2:0] k);
        if (k >= 3'(CHECK_LAST)) return 1'b1;
        return SYNC_CHAR[3'd3 + k];
    endfunction

endpackage

// File: rtl/abs_sync_detect.sv
module abs_sync_detect
    import autobaud_pkg::*;
#(
    parameter int DIV_MIN = 434,
    parameter int DIV_MAX = 83333,
    parameter int DIV_W   = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx,
    output logic             lock_o,
    output logic             locked_o,
    output logic [DIV_W-1:0] div_o
);
    localparam int MW       = DIV_W + 2;
    localparam int IDLE_LEN = 10 * DIV_MAX;
    localparam int IW       = $clog2(IDLE_LEN + 1);
    localparam logic [MW-1:0] MEAS_LIM = MW'(4 * (DIV_MAX + 1));

    typedef struct packed {
        det_state_e       st;
        logic [IW-1:0]    idle;
        logic [MW-1:0]    meas;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       k;
        logic             lock;
    } det_t;

    det_t             det_q, det_d;
    logic [DIV_W-1:0] quarter;

    assign quarter = det_q.meas[MW-1:2];

    always_comb begin
        det_d      = det_q;
        det_d.lock = 1'b0;
        unique case (det_q.st)
            DS_QUIET: begin
                if (rx) begin
                    if (det_q.idle == IW'(IDLE_LEN - 1)) det_d.st = DS_ARMED;
                    else det_d.idle = det_q.idle + 1'b1;
                end else begin
                    det_d.idle = '0;
                end
            end
            DS_ARMED: begin
                if (!rx) begin
                    det_d.st   = DS_MEASURE;
                    det_d.meas = MW'(1);
                end
            end
            DS_MEASURE: begin
                if (!rx) begin
                    if (det_q.meas == MEAS_LIM) begin
                        det_d.st   = DS_QUIET;
                        det_d.idle = '0;
                    end else begin
                        det_d.meas = det_q.meas + 1'b1;
                    end
                end else if (quarter >= DIV_W'(DIV_MIN) && quarter <= DIV_W'(DIV_MAX)) begin
                    det_d.st  = DS_CHECK;
                    det_d.div = quarter;
                    det_d.cnt = (quarter >> 1) - 1'b1;
                    det_d.k   = '0;
                end else begin
                    det_d.st   = DS_QUIET;
                    det_d.idle = '0;
                end
            end
            DS_CHECK: begin
                if (det_q.cnt == '0) begin
                    if (rx != check_bit(det_q.k)) begin
                        det_d.st   = DS_QUIET;
                        det_d.idle = '0;
                    end else if (det_q.k == 3'(CHECK_LAST)) begin
                        det_d.st   = DS_LOCKED;
                        det_d.lock = 1'b1;
                    end else begin
                        det_d.k   = det_q.k + 1'b1;
                        det_d.cnt = det_q.div - 1'b1;
                    end
                end else begin
                    det_d.cnt = det_q.cnt - 1'b1;
                end
            end
            DS_LOCKED: det_d.st = DS_LOCKED;
            default:   det_d.st = DS_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '{st: DS_QUIET, default: '0};
        else        det_q <= det_d;
    end

    assign lock_o   = det_q.lock;
    assign locked_o = (det_q.st == DS_LOCKED);
    assign div_o    = locked_o ? det_q.div : '0;

endmodule

// File: rtl/abs_uart_rx.sv
module abs_uart_rx
    import autobaud_pkg::*;
#(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx,
    input  logic [DIV_W-1:0] div,
    output logic [7:0]       data_o,
    output logic             valid_o
);
    typedef struct packed {
        rx_state_e        st;
        logic             prev;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       n;
        logic [7:0]       sh;
        logic [7:0]       data;
        logic             valid;
    } rxs_t;

    rxs_t rx_q, rx_d;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.prev  = rx;
        unique case (rx_q.st)
            RS_IDLE: begin
                if (en && rx_q.prev && !rx) begin
                    rx_d.st  = RS_START;
                    rx_d.cnt = (div >> 1) - 1'b1;
                end
            end
            RS_START: begin
                if (rx_q.cnt == '0) begin
                    if (!rx) begin
                        rx_d.st  = RS_DATA;
                        rx_d.cnt = div - 1'b1;
                        rx_d.n   = '0;
                    end else begin
                        rx_d.st = RS_IDLE;
                    end
                end else begin
                    rx_d.cnt = rx_q.cnt - 1'b1;
                end
            end
            RS_DATA: begin
                if (rx_q.cnt == '0) begin
                    rx_d.sh  = {rx, rx_q.sh[7:1]};
                    rx_d.cnt = div - 1'b1;
                    rx_d.n   = rx_q.n + 1'b1;
                    if (rx_q.n == 3'd7) rx_d.st = RS_STOP;
                end else begin
                    rx_d.cnt = rx_q.cnt - 1'b1;
                end
            end
            RS_STOP: begin
                if (rx_q.cnt == '0) begin
                    rx_d.st = RS_IDLE;
                    if (rx) begin
                        rx_d.valid = 1'b1;
                        rx_d.data  = rx_q.sh;
                    end
                end else begin
                    rx_d.cnt = rx_q.cnt - 1'b1;
                end
            end
            default: rx_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '{st: RS_IDLE, prev: 1'b1, default: '0};
        else        rx_q <= rx_d;
    end

    assign data_o  = rx_q.data;
    assign valid_o = rx_q.valid;

endmodule

// File: rtl/abs_id_tx.sv
module abs_id_tx
    import autobaud_pkg::*;
#(
    parameter int DIV_W = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DIV_W-1:0]      div,
    input  logic [8*ID_CFG-1:0]   id_table,
    output logic                  tx_o
);
    localparam int IXW = $clog2(ID_LEN);

    logic [7:0] reply [ID_LEN];

    for (genvar i = 0; i < ID_LEN; i++) begin : g_reply
        if (i < ID_CFG) begin : g_cfg
            assign reply[i] = id_table[8*i +: 8];
        end else if (i == ID_CFG) begin : g_lf
            assign reply[i] = ID_LF;
        end else begin : g_cr
            assign reply[i] = ID_CR;
        end
    end

    typedef struct packed {
        logic             busy;
        logic [IXW-1:0]   idx;
        logic [3:0]       n;
        logic [DIV_W-1:0] cnt;
        logic [9:0]       sh;
        logic             line;
    } txs_t;

    txs_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        if (!tx_q.busy) begin
            if (start) begin
                tx_d.busy = 1'b1;
                tx_d.idx  = '0;
                tx_d.n    = '0;
                tx_d.cnt  = div - 1'b1;
                tx_d.sh   = {1'b1, reply[0], 1'b0};
            end
        end else if (tx_q.cnt != '0) begin
            tx_d.cnt = tx_q.cnt - 1'b1;
        end else if (tx_q.n != 4'd9) begin
            tx_d.sh  = {1'b1, tx_q.sh[9:1]};
            tx_d.n   = tx_q.n + 1'b1;
            tx_d.cnt = div - 1'b1;
        end else if (tx_q.idx == IXW'(ID_LEN - 1)) begin
            tx_d.busy = 1'b0;
        end else begin
            tx_d.idx = tx_q.idx + 1'b1;
            tx_d.n   = '0;
            tx_d.cnt = div - 1'b1;
            tx_d.sh  = {1'b1, reply[tx_q.idx + 1'b1], 1'b0};
        end
        tx_d.line = tx_d.busy ? tx_d.sh[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '{line: 1'b1, sh: '1, default: '0};
        else        tx_q <= tx_d;
    end

    assign tx_o = tx_q.line;

endmodule

// File: rtl/uart_autobaud_sync.sv
module uart_autobaud_sync
    import autobaud_pkg::*;
#(
    parameter int  DIV_MIN = 434,
    parameter int  DIV_MAX = 83333,
    localparam int DIV_W   = $clog2(DIV_MAX + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_i,
    input  logic [8*ID_CFG-1:0] id_table_i,
    output logic                tx_o,
    output logic [DIV_W-1:0]    baud_div_o,
    output logic                synced_o,
    output logic [7:0]          rx_data_o,
    output logic                rx_valid_o
);
    logic [1:0] rx_sync_q;
    logic       rx_s;
    logic       lock_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync_q <= 2'b11;
        else        rx_sync_q <= {rx_sync_q[0], rx_i};
    end
    assign rx_s = rx_sync_q[1];

    abs_sync_detect #(
        .DIV_MIN (DIV_MIN),
        .DIV_MAX (DIV_MAX),
        .DIV_W   (DIV_W)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx       (rx_s),
        .lock_o   (lock_evt),
        .locked_o (synced_o),
        .div_o    (baud_div_o)
    );

    abs_uart_rx #(
        .DIV_W (DIV_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (synced_o),
        .rx      (rx_s),
        .div     (baud_div_o),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o)
    );

    abs_id_tx #(
        .DIV_W (DIV_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (lock_evt),
        .div      (baud_div_o),
        .id_table (id_table_i),
        .tx_o     (tx_o)
    );

endmodule

// File: rtl/uart_autobaud_sync_chk.sv
module uart_autobaud_sync_chk #(
    parameter int DIV_MIN = 434,
    parameter int DIV_MAX = 83333,
    parameter int DIV_W   = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_o,
    input logic             synced_o,
    input logic [DIV_W-1:0] baud_div_o,
    input logic             rx_valid_o
);
    p_div_zero_unsynced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !synced_o |-> baud_div_o == '0);

    p_div_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        synced_o |-> (baud_div_o >= DIV_W'(DIV_MIN) && baud_div_o <= DIV_W'(DIV_MAX)));

    p_synced_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        synced_o |=> synced_o);

    p_div_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        synced_o |=> $stable(baud_div_o));

    p_tx_quiet_unsynced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !synced_o |-> tx_o);

    p_valid_after_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> synced_o);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

endmodule

bind uart_autobaud_sync uart_autobaud_sync_chk #(
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX),
    .DIV_W   (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_o       (tx_o),
    .synced_o   (synced_o),
    .baud_div_o (baud_div_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/sim_uart_autobaud_sync.sv
module sim_uart_autobaud_sync;
    localparam int TB_MIN  = 8;
    localparam int TB_MAX  = 40;
    localparam int DW      = $clog2(TB_MAX + 2);
    localparam int IDLE_OK = 10 * TB_MAX + 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_i = 1'b1;
    logic [175:0]  id_table;
    logic          tx_o;
    logic [DW-1:0] baud_div;
    logic          synced;
    logic [7:0]    rx_data;
    logic          rx_valid;

    int checks = 0;
    int fails  = 0;
    int rx_cnt = 0;
    int tx_low = 0;
    logic [7:0] rx_last = '0;
    int rep [24];
    int rep_err;

    always #2 clk = ~clk;

    uart_autobaud_sync #(.DIV_MIN(TB_MIN), .DIV_MAX(TB_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .id_table_i(id_table),
        .tx_o(tx_o), .baud_div_o(baud_div), .synced_o(synced),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid)
    );

    function automatic int id_byte(input int i);
        if (i < 22) return (i * 37 + 5) & 255;
        if (i == 22) return 8'h0A;
        return 8'h0D;
    endfunction

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
        if (!tx_o) tx_low <= tx_low + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_i  = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_byte(input int T, input logic [7:0] b, input logic stopv);
        rx_i = 1'b0;
        repeat (T) @(negedge clk);
        for (int j = 0; j < 8; j++) begin
            rx_i = b[j];
            repeat (T) @(negedge clk);
        end
        rx_i = stopv;
        repeat (T) @(negedge clk);
        rx_i = 1'b1;
    endtask

    task automatic recv_reply(input int T, output int lat);
        int n;
        int b;
        n = 0;
        rep_err = 0;
        while (tx_o && n < 20 * T) begin @(negedge clk); n++; end
        lat = n;
        for (int i = 0; i < 24; i++) begin
            if (i > 0) begin
                n = 0;
                while (tx_o && n < 3 * T) begin @(negedge clk); n++; end
            end
            if (tx_o) begin
                rep[i] = -1;
            end else begin
                repeat (T / 2) @(negedge clk);
                if (tx_o) rep_err++;
                b = 0;
                for (int j = 0; j < 8; j++) begin
                    repeat (T) @(negedge clk);
                    b = b | (int'(tx_o) << j);
                end
                repeat (T) @(negedge clk);
                if (!tx_o) rep_err++;
                rep[i] = b;
            end
        end
    endtask

    task automatic sync_and_reply(input int T);
        int lat;
        lat = 0;
        fork
            send_byte(T, 8'h08, 1'b1);
            recv_reply(T, lat);
        join
        repeat (4) @(negedge clk);
        chk("R5 synced after valid sync", int'(synced), 1);
        chk("R5 divisor equals bit time", int'(baud_div), T);
        chk("R7 reply start latency in window", int'(lat >= 9 * T && lat <= 12 * T), 1);
        for (int i = 0; i < 24; i++) chk($sformatf("R6 reply byte %0d", i), rep[i], id_byte(i));
        chk("R6 reply framing errors", rep_err, 0);
    endtask

    task automatic expect_no_lock(input string req);
        repeat (20) @(negedge clk);
        chk(req, int'(synced), 0);
        chk(req, int'(tx_o), 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tx idle high", int'(tx_o), 1);
        chk("R1 synced low", int'(synced), 0);
        chk("R1 divisor zero", int'(baud_div), 0);
        chk("R1 rx_valid low", int'(rx_valid), 0);
    endtask

    task automatic t_idle_guard();
        do_reset();
        repeat (20) @(negedge clk);
        send_byte(16, 8'h08, 1'b1);
        expect_no_lock("R2 sync before idle guard ignored");
        chk("R2 divisor still zero", int'(baud_div), 0);
        repeat (IDLE_OK) @(negedge clk);
        sync_and_reply(16);
    endtask

    task automatic t_range();
        do_reset();
        repeat (IDLE_OK) @(negedge clk);
        send_byte(TB_MIN - 1, 8'h08, 1'b1);
        expect_no_lock("R4 bit time below minimum rejected");
        repeat (IDLE_OK) @(negedge clk);
        send_byte(TB_MAX + 1, 8'h08, 1'b1);
        expect_no_lock("R4 bit time above maximum rejected");
        repeat (IDLE_OK) @(negedge clk);
        sync_and_reply(TB_MAX);
        do_reset();
        repeat (IDLE_OK) @(negedge clk);
        sync_and_reply(TB_MIN);
    endtask

    task automatic t_wrong_char();
        do_reset();
        repeat (IDLE_OK) @(negedge clk);
        send_byte(16, 8'h18, 1'b1);
        expect_no_lock("R3 char 0x18 rejected");
        repeat (IDLE_OK) @(negedge clk);
        send_byte(16, 8'h00, 1'b1);
        expect_no_lock("R3 char 0x00 rejected");
        repeat (IDLE_OK) @(negedge clk);
        sync_and_reply(12);
    endtask

    task automatic t_after_lock();
        int c0;
        int l0;
        c0 = rx_cnt;
        l0 = tx_low;
        repeat (30) @(negedge clk);
        send_byte(12, 8'h08, 1'b1);
        repeat (5) @(negedge clk);
        chk("R8 later 0x08 delivered", rx_cnt - c0, 1);
        chk("R8 later 0x08 data", int'(rx_last), 8'h08);
        chk("R8 synced held", int'(synced), 1);
        chk("R8 divisor held", int'(baud_div), 12);
        send_byte(12, 8'hA5, 1'b1);
        repeat (5) @(negedge clk);
        chk("R8 data byte 0xA5 count", rx_cnt - c0, 2);
        chk("R8 data byte 0xA5 value", int'(rx_last), 8'hA5);
        send_byte(12, 8'h5A, 1'b0);
        repeat (40) @(negedge clk);
        chk("R9 low stop bit dropped", rx_cnt - c0, 2);
        send_byte(12, 8'h3C, 1'b1);
        repeat (5) @(negedge clk);
        chk("R9 next byte after framing error count", rx_cnt - c0, 3);
        chk("R9 next byte after framing error value", int'(rx_last), 8'h3C);
        chk("R7 no second reply", tx_low - l0, 0);
    endtask

    initial begin
        for (int i = 0; i < 22; i++) id_table[8*i +: 8] = 8'(id_byte(i));
        t_reset();
        t_idle_guard();
        t_range();
        t_wrong_char();
        t_after_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all-reqs act=timeout exp=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule